// File: doc/BRIEF.md
# Dual-Select Static RAM Model

This block is a clocked model of a small static memory: 256 words of 4 bits, with a write data port and a read data port kept apart. Two select inputs of opposite sense have to agree before any access takes place. A read/write strobe picks the operation. An output-disable input can switch the read port off at any time.

The output bus is a 4-bit value together with an enable flag. The flag stands in for the high-impedance state of a tri-state pin. When the flag is low, the value is held at zero, so that the outputs of several such blocks can be merged with a simple OR. Reads are registered: both the data and the flag appear one clock after the address and controls are applied.

Storage is split into four bit planes. In each plane, the low five address bits pick one of 32 rows and the high three bits pick one of 8 columns.

Top module: `dual_sel_sram`

## Requirements
- R1: The memory holds 256 distinct 4-bit words; every address keeps its own value independently of the others.
- R2: The block is selected only when `sel_n` is 0 and `sel` is 1; in all three other combinations `q_en` is 0 one clock later.
- R3: When selected with `q_off` = 0 and `rd_wr` = 1, `q_en` is 1 one clock later and `q` holds the word most recently written to `addr`.
- R4: When selected with `rd_wr` = 0, the word on `d` is stored at `addr` on that clock edge, and `q_en` is 0 one clock later.
- R5: When `q_off` is 1, `q_en` is 0 one clock later, whatever the select and strobe inputs are.
- R6: Whenever `q_en` is 0, `q` is all zeros.
- R7: While the block is not selected, `addr`, `d` and `rd_wr` have no effect: no stored word changes.
- R8: `addr[4:0]` selects the row and `addr[7:5]` selects the column; two addresses that differ only in row bits, or only in column bits, refer to different words.
- R9: While `rst_n` is 0 at a clock edge, `q_en` and `q` are 0 after that edge; stored contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 8 | Word address: bits 4:0 give the row, bits 7:5 give the column |
| d | input | 4 | Write data |
| sel_n | input | 1 | Chip select, active low |
| sel | input | 1 | Chip select, active high |
| q_off | input | 1 | Output disable, active high |
| rd_wr | input | 1 | 1 = read, 0 = write |
| q | output | 4 | Read data, zero when not enabled |
| q_en | output | 1 | Read data valid (0 represents high impedance) |

## Verification
The bench walks all four select combinations while a write is attempted with fresh data. It then reads the word back, because a design that decodes only one of the two selects would overwrite it. It writes with `q_off` high and reads with `q_off` high to confirm that the disable blocks the output but not the write. A block that gated writes with the disable, or let it drive data, would fail here. It also writes addresses that differ only in row bits or only in column bits; a decoder with a swapped or truncated field would alias them. The remaining stimulus is seeded random traffic over a narrow address window, so reads often hit written words.

// File: rtl/dual_sel_sram.sv
module dual_sel_sram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4,
  parameter int ROW_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] d,
  input  logic              sel_n,
  input  logic              sel,
  input  logic              q_off,
  input  logic              rd_wr,
  output logic [DATA_W-1:0] q,
  output logic              q_en
);
  localparam int COL_W = ADDR_W - ROW_W;
  localparam int ROWS  = 1 << ROW_W;
  localparam int COLS  = 1 << COL_W;

  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  logic              picked, do_wr, do_rd;
  logic [DATA_W-1:0] rd_bits;

  assign row    = addr[ROW_W-1:0];
  assign col    = addr[ADDR_W-1:ROW_W];
  assign picked = !sel_n && sel;
  assign do_wr  = picked && !rd_wr;
  assign do_rd  = picked && rd_wr && !q_off;

  for (genvar b = 0; b < DATA_W; b++) begin : g_plane
    logic [COLS-1:0] cells [ROWS];
    always_ff @(posedge clk)
      if (do_wr) cells[row][col] <= d[b];
    assign rd_bits[b] = cells[row][col];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_en <= 1'b0;
      q    <= '0;
    end else begin
      q_en <= do_rd;
      q    <= do_rd ? rd_bits : '0;
    end
  end
endmodule

module dual_sel_sram_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              sel_n,
  input logic              sel,
  input logic              q_off,
  input logic              rd_wr,
  input logic [DATA_W-1:0] q,
  input logic              q_en
);
  assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sel_n && sel) |=> !q_en);
  assert_read_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel && rd_wr && !q_off) |=> q_en);
  assert_write_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel && !rd_wr) |=> !q_en);
  assert_disable_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    q_off |=> !q_en);
  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !q_en |-> (q == '0));
  assert_read_data_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel && rd_wr && !q_off && $stable(addr) && $past(!sel_n && sel && rd_wr && !q_off))
    |=> $stable(q));
endmodule

bind dual_sel_sram dual_sel_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .sel(sel),
  .q_off(q_off), .rd_wr(rd_wr), .q(q), .q_en(q_en)
);

// File: tb/test_dual_sel_sram.sv
`timescale 1ns/1ps
module test_dual_sel_sram;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic [3:0] d = '0;
  logic       sel_n = 1'b1, sel = 1'b0, q_off = 1'b0, rd_wr = 1'b1;
  logic [3:0] q;
  logic       q_en;

  int n_run = 0, n_fail = 0;
  logic [3:0] model [256];
  bit         known [256];

  always #2 clk = ~clk;

  dual_sel_sram i_dual_sel_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .d(d), .sel_n(sel_n), .sel(sel),
    .q_off(q_off), .rd_wr(rd_wr), .q(q), .q_en(q_en)
  );

  function automatic bit exp_en(bit s_n, bit s, bit off, bit rw);
    return !s_n && s && rw && !off;
  endfunction

  task automatic op(input bit s_n, input bit s, input bit off, input bit rw,
                    input logic [7:0] a, input logic [3:0] wd, input string tag);
    bit en;
    bit chk_data;
    logic [3:0] exp_q;
    @(negedge clk);
    sel_n = s_n; sel = s; q_off = off; rd_wr = rw; addr = a; d = wd;
    en = exp_en(s_n, s, off, rw);
    chk_data = !en || known[a];
    exp_q = en ? model[a] : 4'h0;
    if (!s_n && s && !rw) begin
      model[a] = wd;
      known[a] = 1'b1;
    end
    @(negedge clk);
    n_run++;
    if (q_en !== en || (chk_data && q !== exp_q)) begin
      n_fail++;
      $display("FAIL %s addr=%02h q_en=%0b q=%h expected q_en=%0b q=%h",
               tag, a, q_en, q, en, exp_q);
    end
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) known[i] = 1'b0;
    repeat (3) @(negedge clk);
    n_run++;
    if (q_en !== 1'b0 || q !== 4'h0) begin
      n_fail++;
      $display("FAIL R9 q_en=%0b q=%h expected q_en=0 q=0", q_en, q);
    end
    rst_n = 1'b1;

    op(0, 1, 0, 0, 8'h15, 4'hA, "R4 write");
    op(0, 1, 0, 1, 8'h15, 4'h0, "R3 read");
    // R2/R7: each non-selecting combination tries to overwrite 0x15
    op(1, 1, 0, 0, 8'h15, 4'h3, "R2 standby sel_n=1");
    op(0, 0, 0, 0, 8'h15, 4'h3, "R2 standby sel=0");
    op(1, 0, 0, 0, 8'h15, 4'h3, "R2 standby both off");
    op(1, 1, 0, 1, 8'h15, 4'h3, "R2 standby read attempt");
    op(0, 1, 0, 1, 8'h15, 4'h0, "R7 contents kept");
    // R5: disable during write still stores, during read blocks output
    op(0, 1, 1, 0, 8'h40, 4'h6, "R5 write with q_off");
    op(0, 1, 1, 1, 8'h40, 4'h0, "R5 read with q_off");
    op(1, 0, 1, 1, 8'h40, 4'h0, "R5 q_off in standby");
    op(0, 1, 0, 1, 8'h40, 4'h0, "R5 write under q_off landed");
    // R8: row-only and column-only neighbours
    op(0, 1, 0, 0, 8'h00, 4'h1, "R8 base");
    op(0, 1, 0, 0, 8'h1F, 4'h2, "R8 row max");
    op(0, 1, 0, 0, 8'hE0, 4'h4, "R8 column max");
    op(0, 1, 0, 0, 8'h20, 4'h8, "R8 column 1");
    op(0, 1, 0, 0, 8'hFF, 4'hF, "R8 top");
    op(0, 1, 0, 1, 8'h00, 4'h0, "R8 read base");
    op(0, 1, 0, 1, 8'h1F, 4'h0, "R8 read row max");
    op(0, 1, 0, 1, 8'hE0, 4'h0, "R8 read column max");
    op(0, 1, 0, 1, 8'h20, 4'h0, "R8 read column 1");
    op(0, 1, 0, 1, 8'hFF, 4'h0, "R8 read top");
    // R1: fill every word, then read all back
    for (int i = 0; i < 256; i++)
      op(0, 1, 0, 0, 8'(i), 4'((i * 7 + 3) & 15), "R1 fill");
    for (int i = 0; i < 256; i++)
      op(0, 1, 0, 1, 8'(i), 4'h0, "R1 readback");
    // R6 and the rest: seeded random traffic
    for (int i = 0; i < 1500; i++) begin
      bit s_n, s, off, rw;
      logic [7:0] a;
      s_n = ($urandom % 4) == 0;
      s   = ($urandom % 4) != 0;
      off = ($urandom % 5) == 0;
      rw  = ($urandom % 2) == 0;
      a   = (($urandom % 3) == 0) ? 8'($urandom) : 8'($urandom % 16);
      op(s_n, s, off, rw, a, 4'($urandom), "R6 random");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule